// File: doc/BRIEF.md
# Interrupt Masking Controller with Fatal and Nonfatal Classes

This block collects interrupt conditions from a bus-protocol group (two 8-bit status registers) and a DMA group (one 8-bit status register). Each incoming event pulse is latched into its own status bit. A matching enable bit in one of three enable registers decides whether that condition may drive the active-low interrupt pin.

Every condition is classed as fatal or nonfatal. The class, together with the enable, decides three things: whether the script engine receives a halt request, whether the group's pending summary bit is set, and whether the pin is pulled low. A masked nonfatal condition only logs status. A masked fatal condition still halts execution and still raises its group summary, but it leaves the pin high.

The CPU reaches the registers through a plain read/write port. A status read returns the register and clears it. The attention condition counts as nonfatal only while the device runs in target mode.

Top module: `irq_mask_ctrl`

## Requirements
- R1: An event pulse on any input bit sets the matching status bit at the next clock edge, whatever its enable or class.
- R2: A read of a status register (address 0 = bus register 0, 1 = bus register 1, 2 = DMA register) returns its contents in the same cycle and clears it at the next edge. An event on a bit in that same cycle wins, and the bit stays set.
- R3: A set status bit whose enable is 1 drives `irq_n` low from the edge that sets it. `irq_n` returns high only at the edge where no enabled status bit remains set.
- R4: A masked nonfatal condition sets its status bit but leaves its group summary bit at 0, leaves `irq_n` high and gives no halt.
- R5: A masked fatal condition raises `halt_req`, sets its status bit and sets its group summary bit, and leaves `irq_n` high.
- R6: A nonfatal condition never raises `halt_req`, whether or not it is enabled.
- R7: `halt_req` is high for exactly one cycle, after the edge where a fatal status bit goes from clear to set. A repeated event on a bit that is already set gives no new pulse.
- R8: The class of each bit is fixed as follows. In bus register 0, bits 0 to 2 are nonfatal and bits 4 to 7 are fatal. Bit 3 of bus register 0 (attention) is nonfatal when `target_mode` = 1 and fatal when `target_mode` = 0. In bus register 1, bits 0 to 1 are nonfatal and bits 2 to 7 are fatal. In the DMA register, bit 0 is nonfatal and bits 1 to 7 are fatal.
- R9: The enable registers sit at address 3 (bus 0), address 4 (bus 1) and address 5 (DMA). All of them reset to 0, can be written, and read back what was written.
- R10: Address 6 reads the summary, with bit 0 for the bus group and bit 1 for the DMA group. A group bit is 1 while that group holds a status bit that is either enabled or fatal, and it drops to 0 once no such bit remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| target_mode | input | 1 | 1 = target operation, 0 = initiator operation |
| ev_bus0 | input | 8 | Event pulses for bus status register 0 |
| ev_bus1 | input | 8 | Event pulses for bus status register 1 |
| ev_dma | input | 8 | Event pulses for the DMA status register |
| cpu_we | input | 1 | Register write strobe |
| cpu_re | input | 1 | Register read strobe (clears status registers) |
| cpu_addr | input | 3 | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid in the cycle of the read strobe |
| irq_n | output | 1 | Active-low interrupt pin |
| halt_req | output | 1 | One-cycle halt request to the script engine |

## Verification
The embedded assertions check four things on every cycle: an event always lands in its status bit, a read strobe with no event empties the register, and neither a low pin nor a halt pulse can appear unless a group summary bit is set. Only the bench's scenarios can show the class-dependent outcomes. These are the masked-fatal and masked-nonfatal cases, the attention bit changing class with the mode, the halt pulse lasting one cycle with no repeat, and the pin staying low until the last enabled bit has been read away.

// File: rtl/imc_pkg.sv
package imc_pkg;
    localparam int unsigned REG_W  = 8;
    localparam int unsigned NBANK  = 3;
    localparam int unsigned ADDR_W = 3;
    // register addresses
    localparam logic [ADDR_W-1:0] A_ST_BUS0 = 3'd0;
    localparam logic [ADDR_W-1:0] A_ST_BUS1 = 3'd1;
    localparam logic [ADDR_W-1:0] A_ST_DMA  = 3'd2;
    localparam logic [ADDR_W-1:0] A_EN_BASE = 3'd3;
    localparam logic [ADDR_W-1:0] A_SUMMARY = 3'd6;

    typedef struct packed {
        logic irq_n;
        logic halt;
    } out_state_t;
endpackage

// File: rtl/imc_bank.sv
module imc_bank #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev,
    input  logic         clr,
    input  logic         en_we,
    input  logic [W-1:0] en_wdata,
    input  logic [W-1:0] fatal_vec,
    output logic [W-1:0] stat_q,
    output logic [W-1:0] en_q,
    output logic         pend,
    output logic         raise_d,
    output logic         fat_rise_d
);
    typedef struct packed {
        logic [W-1:0] stat;
        logic [W-1:0] en;
    } bank_t;

    bank_t cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        // event wins over a same-cycle clear
        nxt_d.stat = (cur_q.stat & ~{W{clr}}) | ev;
        if (en_we) nxt_d.en = en_wdata;
        raise_d    = |(nxt_d.stat & nxt_d.en);
        fat_rise_d = |(nxt_d.stat & ~cur_q.stat & fatal_vec);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign stat_q = cur_q.stat;
    assign en_q   = cur_q.en;
    assign pend   = |(cur_q.stat & (cur_q.en | fatal_vec));

    // R1
    ev_captured_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev) |=> ((stat_q & $past(ev)) == $past(ev)));
    // R2
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && (ev == '0)) |=> (stat_q == '0));
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl #(
    parameter int unsigned DW       = imc_pkg::REG_W,
    parameter int unsigned AW       = imc_pkg::ADDR_W,
    parameter logic [DW-1:0] NF_BUS0 = 8'h07,
    parameter int unsigned   ATTN_BIT = 3,
    parameter logic [DW-1:0] NF_BUS1 = 8'h03,
    parameter logic [DW-1:0] NF_DMA  = 8'h01
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          target_mode,
    input  logic [DW-1:0] ev_bus0,
    input  logic [DW-1:0] ev_bus1,
    input  logic [DW-1:0] ev_dma,
    input  logic          cpu_we,
    input  logic          cpu_re,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          irq_n,
    output logic          halt_req
);
    import imc_pkg::*;

    localparam int unsigned NB = NBANK;
    localparam logic [DW-1:0] ATTN_MASK = DW'(1) << ATTN_BIT;

    logic [NB-1:0][DW-1:0] ev_a, fat_a, stat_a, en_a;
    logic [NB-1:0]         pend_a, raise_a, frise_a, clr_a, enwe_a;
    logic                  bus_pend, dma_pend;

    always_comb begin
        ev_a[0]  = ev_bus0;
        ev_a[1]  = ev_bus1;
        ev_a[2]  = ev_dma;
        fat_a[0] = ~NF_BUS0 & ~(target_mode ? ATTN_MASK : '0)
                 | (target_mode ? '0 : ATTN_MASK);
        fat_a[1] = ~NF_BUS1;
        fat_a[2] = ~NF_DMA;
    end

    for (genvar i = 0; i < NB; i++) begin : g_bank
        assign clr_a[i]  = cpu_re && (cpu_addr == AW'(i));
        assign enwe_a[i] = cpu_we && (cpu_addr == A_EN_BASE + AW'(i));
        imc_bank #(.W(DW)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .ev         (ev_a[i]),
            .clr        (clr_a[i]),
            .en_we      (enwe_a[i]),
            .en_wdata   (cpu_wdata),
            .fatal_vec  (fat_a[i]),
            .stat_q     (stat_a[i]),
            .en_q       (en_a[i]),
            .pend       (pend_a[i]),
            .raise_d    (raise_a[i]),
            .fat_rise_d (frise_a[i])
        );
    end

    assign bus_pend = pend_a[0] | pend_a[1];
    assign dma_pend = pend_a[2];

    out_state_t out_q, out_d;

    always_comb begin
        out_d       = out_q;
        out_d.irq_n = ~(|raise_a);
        out_d.halt  = |frise_a;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '{irq_n: 1'b1, halt: 1'b0};
        else        out_q <= out_d;
    end

    assign irq_n    = out_q.irq_n;
    assign halt_req = out_q.halt;

    always_comb begin
        cpu_rdata = '0;
        if (cpu_addr == A_ST_BUS0)           cpu_rdata = stat_a[0];
        else if (cpu_addr == A_ST_BUS1)      cpu_rdata = stat_a[1];
        else if (cpu_addr == A_ST_DMA)       cpu_rdata = stat_a[2];
        else if (cpu_addr == A_EN_BASE)      cpu_rdata = en_a[0];
        else if (cpu_addr == A_EN_BASE + 1)  cpu_rdata = en_a[1];
        else if (cpu_addr == A_EN_BASE + 2)  cpu_rdata = en_a[2];
        else if (cpu_addr == A_SUMMARY)      cpu_rdata = {{(DW-2){1'b0}}, dma_pend, bus_pend};
    end

    // R3
    pin_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (bus_pend || dma_pend));
    // R5
    halt_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> (bus_pend || dma_pend));
endmodule

// File: tb/irq_mask_ctrl_bench.sv
module irq_mask_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       target_mode = 1'b0;
    logic [7:0] ev_bus0 = '0, ev_bus1 = '0, ev_dma = '0;
    logic       cpu_we = 1'b0, cpu_re = 1'b0;
    logic [2:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       irq_n, halt_req;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    irq_mask_ctrl u_irq_mask_ctrl (
        .clk(clk), .rst_n(rst_n), .target_mode(target_mode),
        .ev_bus0(ev_bus0), .ev_bus1(ev_bus1), .ev_dma(ev_dma),
        .cpu_we(cpu_we), .cpu_re(cpu_re), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .irq_n(irq_n), .halt_req(halt_req)
    );

    typedef struct packed {
        logic       mode;
        logic [7:0] en0, en1, den;
        logic [7:0] e0, e1, ed;
        logic       x_irq_n;
        logic       x_halt;
        logic [1:0] x_sum;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 1'b1, 1'b0, 2'b00},
        '{1'b0, 8'h01, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 1'b0, 1'b0, 2'b01},
        '{1'b0, 8'h00, 8'h00, 8'h00, 8'h10, 8'h00, 8'h00, 1'b1, 1'b1, 2'b01},
        '{1'b0, 8'h10, 8'h00, 8'h00, 8'h10, 8'h00, 8'h00, 1'b0, 1'b1, 2'b01},
        '{1'b1, 8'h00, 8'h00, 8'h00, 8'h08, 8'h00, 8'h00, 1'b1, 1'b0, 2'b00},
        '{1'b0, 8'h00, 8'h00, 8'h00, 8'h08, 8'h00, 8'h00, 1'b1, 1'b1, 2'b01},
        '{1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h03, 8'h00, 1'b1, 1'b0, 2'b00},
        '{1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h04, 8'h00, 1'b1, 1'b1, 2'b01},
        '{1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 1'b1, 1'b0, 2'b00},
        '{1'b0, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 8'h01, 1'b0, 1'b0, 2'b10},
        '{1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h80, 1'b1, 1'b1, 2'b10},
        '{1'b0, 8'h00, 8'h00, 8'h80, 8'h01, 8'h00, 8'h80, 1'b0, 1'b1, 2'b10},
        '{1'b0, 8'h00, 8'h02, 8'h00, 8'h00, 8'h02, 8'h00, 1'b0, 1'b0, 2'b01}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_re = 1'b1; cpu_addr = a;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_re = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check("R3 reset irq_n", {7'b0, irq_n}, 8'h01);
        check("R7 reset halt", {7'b0, halt_req}, 8'h00);
        for (int a = 3; a < 6; a++) begin
            rd(3'(a), r);
            check("R9 enable reset", r, 8'h00);
        end
        wr(3'd4, 8'hA5);
        rd(3'd4, r);
        check("R9 enable readback", r, 8'hA5);
        wr(3'd4, 8'h00);

        // table walk: R4 R5 R6 R8 R10
        for (int v = 0; v < NV; v++) begin
            vec_t t = TBL[v];
            target_mode = t.mode;
            wr(3'd3, t.en0); wr(3'd4, t.en1); wr(3'd5, t.den);
            @(negedge clk);
            ev_bus0 = t.e0; ev_bus1 = t.e1; ev_dma = t.ed;
            @(negedge clk);
            ev_bus0 = '0; ev_bus1 = '0; ev_dma = '0;
            check($sformatf("R4/R5 irq_n vec %0d", v), {7'b0, irq_n}, {7'b0, t.x_irq_n});
            check($sformatf("R6/R8 halt vec %0d", v), {7'b0, halt_req}, {7'b0, t.x_halt});
            @(negedge clk);
            check($sformatf("R7 halt one cycle vec %0d", v), {7'b0, halt_req}, 8'h00);
            rd(3'd6, r);
            check($sformatf("R10 summary vec %0d", v), r, {6'b0, t.x_sum});
            rd(3'd0, r); check($sformatf("R1 status bus0 vec %0d", v), r, t.e0);
            rd(3'd1, r); check($sformatf("R1 status bus1 vec %0d", v), r, t.e1);
            rd(3'd2, r); check($sformatf("R1 status dma vec %0d", v), r, t.ed);
            check($sformatf("R3 pin released vec %0d", v), {7'b0, irq_n}, 8'h01);
            rd(3'd6, r);
            check($sformatf("R10 summary cleared vec %0d", v), r, 8'h00);
        end
        wr(3'd3, 8'h00); wr(3'd4, 8'h00); wr(3'd5, 8'h00);
        target_mode = 1'b0;

        // R2 event beats same-cycle clear
        @(negedge clk);
        ev_bus0 = 8'h01; cpu_re = 1'b1; cpu_addr = 3'd0;
        @(negedge clk);
        ev_bus0 = '0; cpu_re = 1'b0;
        rd(3'd0, r); check("R2 event wins over clear", r, 8'h01);
        rd(3'd0, r); check("R2 read clears", r, 8'h00);

        // R7 repeated fatal event on set bit: no second pulse
        @(negedge clk);
        ev_bus0 = 8'h20;
        @(negedge clk);
        check("R7 first pulse", {7'b0, halt_req}, 8'h01);
        @(negedge clk);
        check("R7 no repeat pulse", {7'b0, halt_req}, 8'h00);
        ev_bus0 = '0;
        @(negedge clk);
        check("R7 still low", {7'b0, halt_req}, 8'h00);
        rd(3'd0, r); check("R1 fatal bit logged", r, 8'h20);

        // R3 pin held until last enabled bit cleared
        wr(3'd3, 8'h01); wr(3'd4, 8'h01);
        @(negedge clk);
        ev_bus0 = 8'h01; ev_bus1 = 8'h01;
        @(negedge clk);
        ev_bus0 = '0; ev_bus1 = '0;
        check("R3 pin asserted", {7'b0, irq_n}, 8'h00);
        rd(3'd0, r);
        check("R3 pin held with one pending", {7'b0, irq_n}, 8'h00);
        rd(3'd1, r);
        check("R3 pin released after last", {7'b0, irq_n}, 8'h01);
        wr(3'd3, 8'h00); wr(3'd4, 8'h00);

        // R6 enabled nonfatal in DMA group never halts
        wr(3'd5, 8'h01);
        @(negedge clk);
        ev_dma = 8'h01;
        @(negedge clk);
        ev_dma = '0;
        check("R6 enabled nonfatal no halt", {7'b0, halt_req}, 8'h00);
        rd(3'd2, r);
        check("R2 dma status read", r, 8'h01);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule